// File: doc/BRIEF.md
# Supervisory Interrupt Event Gate

This block collects status levels from several supervisory monitors and turns each one into a single-cycle event. Each monitor has its own trigger rule. Temperature warning and ground offset trigger on either edge. Battery supervision triggers on a falling edge. The supply-good vector triggers when any of its bits drops from 1 to 0. The bus-fault vector triggers on any change of its value. Each event passes only when its enable bit is set. It then sets a sticky flag, and any set flag pulls the active-low interrupt output low.

A watchdog overflow pulse is handled by mode. In standby mode with the watchdog-interrupt enable set, the overflow sets a flag. In standby mode with that enable clear, it becomes a one-cycle reset request instead. Outside standby it does neither. Software clears flags with a strobe and a bit mask. The enable vector and the clear mask use the same bit positions as the flag vector.

Top module: `irq_evt_gate`

## Requirements
- R1: While reset is active and after it is released, flags_o is 0, int_n_o is 1 and rst_req_o is 0. The first clock edge after reset never creates an event, whatever the input levels are.
- R2: With en_i[4] set, a rising or a falling edge of temp_warn_i sets flags_o[4] at the next clock edge.
- R3: With en_i[3] set, a rising or a falling edge of gnd_shift_i sets flags_o[3] at the next clock edge.
- R4: With en_i[2] set, a falling edge of batt_ok_i sets flags_o[2] at the next clock edge. A rising edge sets nothing.
- R5: With en_i[1] set, any bit of pwr_good_i going from 1 to 0 sets flags_o[1]. Bits going from 0 to 1 set nothing.
- R6: With en_i[0] set, any change in the value of bus_fault_i sets flags_o[0].
- R7: A wdt_ovf_i pulse while standby_i is 1 sets flags_o[5] if en_i[5] is 1. If en_i[5] is 0, it drives rst_req_o high for exactly the following cycle and sets no flag. Outside standby it causes neither.
- R8: A source whose enable bit is 0 never sets its flag. Setting the enable later does not set the flag for an earlier edge.
- R9: Flags are sticky. A cycle with clr_stb_i high clears exactly the flags whose clr_mask_i bit is 1. A mask presented without the strobe has no effect.
- R10: When an event and a clear of the same flag fall in the same cycle, the flag remains set.
- R11: int_n_o is 0 exactly when at least one flag is set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| temp_warn_i | input | 1 | Temperature warning level |
| gnd_shift_i | input | 1 | Ground offset over limit |
| batt_ok_i | input | 1 | Battery supervision level |
| pwr_good_i | input | SUP_W | Supply-good bits |
| bus_fault_i | input | BUS_W | Bus transceiver fault status vector |
| wdt_ovf_i | input | 1 | Watchdog overflow pulse |
| standby_i | input | 1 | Standby mode indication |
| en_i | input | 6 | Enables: [0] bus, [1] supply, [2] battery, [3] ground, [4] temperature, [5] watchdog |
| clr_stb_i | input | 1 | Flag clear strobe |
| clr_mask_i | input | 6 | Flags to clear, same bit positions as en_i |
| flags_o | output | 6 | Sticky interrupt flags |
| int_n_o | output | 1 | Active-low interrupt |
| rst_req_o | output | 1 | Reset request pulse |

## Verification
A source edge is registered against its previous value at one clock edge, and the flag appears after that same edge. A flag therefore becomes visible one edge after its input changes. The reset request also appears one edge after the overflow pulse and drops at the following edge. int_n_o follows the flags with no extra register. The bench drives every input on the falling clock edge and steps to the next falling edge before sampling. One step is the full latency of each result, so the pulse checks sample the reset request exactly twice: once high and once low again.

// File: rtl/irq_evt_pkg.sv
package irq_evt_pkg;
   localparam int NFLAG   = 6;
   localparam int FLG_BUS = 0;
   localparam int FLG_PWR = 1;
   localparam int FLG_BAT = 2;
   localparam int FLG_GND = 3;
   localparam int FLG_TMP = 4;
   localparam int FLG_WDT = 5;

   typedef enum logic [1:0] {
      EDGE_ANY      = 2'd0,
      EDGE_FALL_ANY = 2'd1,
      EDGE_RISE_ANY = 2'd2
   } edge_mode_e;
endpackage

// File: rtl/irq_edge_det.sv
module irq_edge_det
   import irq_evt_pkg::*;
#(
   parameter int         W    = 1,
   parameter edge_mode_e MODE = EDGE_ANY
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic         arm_i,
   input  logic [W-1:0] sig_i,
   output logic         evt_o
);
   logic [W-1:0] prev_q;
   logic         raw;

   if (W < 1) begin : g_bad_w
      $error("irq_edge_det: W must be at least 1");
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q <= '0;
      else        prev_q <= sig_i;
   end

   if (MODE == EDGE_FALL_ANY) begin : g_fall
      assign raw = |(prev_q & ~sig_i);
   end else if (MODE == EDGE_RISE_ANY) begin : g_rise
      assign raw = |(~prev_q & sig_i);
   end else begin : g_any
      assign raw = |(prev_q ^ sig_i);
   end

   assign evt_o = arm_i & raw;
endmodule

// File: rtl/irq_wdt_route.sv
module irq_wdt_route (
   input  logic clk,
   input  logic rst_n,
   input  logic ovf_i,
   input  logic standby_i,
   input  logic irq_en_i,
   output logic irq_evt_o,
   output logic rst_req_o
);
   logic hit;
   logic rst_req_q;

   assign hit       = ovf_i & standby_i;
   assign irq_evt_o = hit & irq_en_i;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) rst_req_q <= 1'b0;
      else        rst_req_q <= hit & ~irq_en_i;
   end

   assign rst_req_o = rst_req_q;
endmodule

// File: rtl/irq_flag_bank.sv
module irq_flag_bank #(
   parameter int N = 6
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [N-1:0] set_i,
   input  logic         clr_stb_i,
   input  logic [N-1:0] clr_mask_i,
   output logic [N-1:0] flags_o
);
   logic [N-1:0] flags_q;
   logic [N-1:0] clr_eff;

   if (N < 1) begin : g_bad_n
      $error("irq_flag_bank: N must be at least 1");
   end

   assign clr_eff = clr_stb_i ? clr_mask_i : '0;

   for (genvar i = 0; i < N; i++) begin : g_bit
      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)        flags_q[i] <= 1'b0;
         else if (set_i[i]) flags_q[i] <= 1'b1;
         else if (clr_eff[i]) flags_q[i] <= 1'b0;
      end
   end

   assign flags_o = flags_q;
endmodule

// File: rtl/irq_evt_gate.sv
module irq_evt_gate
   import irq_evt_pkg::*;
#(
   parameter int SUP_W = 3,
   parameter int BUS_W = 3
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             temp_warn_i,
   input  logic             gnd_shift_i,
   input  logic             batt_ok_i,
   input  logic [SUP_W-1:0] pwr_good_i,
   input  logic [BUS_W-1:0] bus_fault_i,
   input  logic             wdt_ovf_i,
   input  logic             standby_i,
   input  logic [5:0]       en_i,
   input  logic             clr_stb_i,
   input  logic [5:0]       clr_mask_i,
   output logic [5:0]       flags_o,
   output logic             int_n_o,
   output logic             rst_req_o
);
   localparam int NLVL = 2;

   if (SUP_W < 1 || SUP_W > 16) begin : g_bad_sup
      $error("irq_evt_gate: SUP_W out of range");
   end
   if (BUS_W < 1 || BUS_W > 16) begin : g_bad_bus
      $error("irq_evt_gate: BUS_W out of range");
   end
   if (NFLAG != 6) begin : g_bad_nflag
      $error("irq_evt_gate: flag count mismatch");
   end

   logic             arm_q;
   logic [NFLAG-1:0] evt;
   logic [NFLAG-1:0] set;
   logic [NLVL-1:0]  lvl_sig;
   logic [NLVL-1:0]  lvl_evt;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) arm_q <= 1'b0;
      else        arm_q <= 1'b1;
   end

   assign lvl_sig = {temp_warn_i, gnd_shift_i};

   for (genvar k = 0; k < NLVL; k++) begin : g_lvl
      irq_edge_det #(.W(1), .MODE(EDGE_ANY)) u_det (
         .clk   (clk),
         .rst_n (rst_n),
         .arm_i (arm_q),
         .sig_i (lvl_sig[k]),
         .evt_o (lvl_evt[k])
      );
   end

   assign evt[FLG_GND] = lvl_evt[0];
   assign evt[FLG_TMP] = lvl_evt[1];

   irq_edge_det #(.W(1), .MODE(EDGE_FALL_ANY)) u_bat (
      .clk   (clk),
      .rst_n (rst_n),
      .arm_i (arm_q),
      .sig_i (batt_ok_i),
      .evt_o (evt[FLG_BAT])
   );

   irq_edge_det #(.W(SUP_W), .MODE(EDGE_FALL_ANY)) u_pwr (
      .clk   (clk),
      .rst_n (rst_n),
      .arm_i (arm_q),
      .sig_i (pwr_good_i),
      .evt_o (evt[FLG_PWR])
   );

   irq_edge_det #(.W(BUS_W), .MODE(EDGE_ANY)) u_bus (
      .clk   (clk),
      .rst_n (rst_n),
      .arm_i (arm_q),
      .sig_i (bus_fault_i),
      .evt_o (evt[FLG_BUS])
   );

   irq_wdt_route u_wdt (
      .clk       (clk),
      .rst_n     (rst_n),
      .ovf_i     (wdt_ovf_i),
      .standby_i (standby_i),
      .irq_en_i  (en_i[FLG_WDT]),
      .irq_evt_o (evt[FLG_WDT]),
      .rst_req_o (rst_req_o)
   );

   assign set = evt & en_i;

   irq_flag_bank #(.N(NFLAG)) u_flags (
      .clk        (clk),
      .rst_n      (rst_n),
      .set_i      (set),
      .clr_stb_i  (clr_stb_i),
      .clr_mask_i (clr_mask_i),
      .flags_o    (flags_o)
   );

   assign int_n_o = ~|flags_o;
endmodule

// File: rtl/irq_evt_gate_chk.sv
module irq_evt_gate_chk (
   input logic       clk,
   input logic       rst_n,
   input logic       temp_warn_i,
   input logic       batt_ok_i,
   input logic       wdt_ovf_i,
   input logic       standby_i,
   input logic [5:0] en_i,
   input logic       clr_stb_i,
   input logic [5:0] clr_mask_i,
   input logic [5:0] flags_o,
   input logic       int_n_o,
   input logic       rst_req_o
);
   logic armed;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) armed <= 1'b0;
      else        armed <= 1'b1;
   end

   // R9
   p_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> (($past(flags_o) & ~($past(clr_stb_i) ? $past(clr_mask_i) : 6'b0)
                 & ~flags_o) == 6'b0));

   // R8
   p_gated_r8: assert property (@(posedge clk) disable iff (!rst_n)
      1'b1 |=> ((flags_o & ~$past(flags_o) & ~$past(en_i)) == 6'b0));

   // R11
   p_int_pin_r11: assert property (@(posedge clk) disable iff (!rst_n)
      (|flags_o) == !int_n_o);

   // R4
   p_bat_fall_r4: assert property (@(posedge clk) disable iff (!rst_n)
      (armed && en_i[2] && $fell(batt_ok_i)) |=> flags_o[2]);

   // R2
   p_tmp_edge_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (armed && en_i[4] && ($rose(temp_warn_i) || $fell(temp_warn_i))) |=> flags_o[4]);

   // R7
   p_wdt_reset_r7: assert property (@(posedge clk) disable iff (!rst_n)
      (wdt_ovf_i && standby_i && !en_i[5]) |=> rst_req_o);

   // R7
   p_wdt_quiet_r7: assert property (@(posedge clk) disable iff (!rst_n)
      !(wdt_ovf_i && standby_i) |=> !rst_req_o);

   // R1
   p_reset_idle_r1: assert property (@(posedge clk)
      !rst_n |-> (flags_o == 6'b0 && int_n_o && !rst_req_o));
endmodule

bind irq_evt_gate irq_evt_gate_chk u_chk (
   .clk         (clk),
   .rst_n       (rst_n),
   .temp_warn_i (temp_warn_i),
   .batt_ok_i   (batt_ok_i),
   .wdt_ovf_i   (wdt_ovf_i),
   .standby_i   (standby_i),
   .en_i        (en_i),
   .clr_stb_i   (clr_stb_i),
   .clr_mask_i  (clr_mask_i),
   .flags_o     (flags_o),
   .int_n_o     (int_n_o),
   .rst_req_o   (rst_req_o)
);

// File: tb/sim_irq_evt_gate.sv
`timescale 1ns/1ps
module sim_irq_evt_gate;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic       temp_warn_i = 1'b0;
   logic       gnd_shift_i = 1'b0;
   logic       batt_ok_i = 1'b1;
   logic [2:0] pwr_good_i = 3'b111;
   logic [2:0] bus_fault_i = 3'b000;
   logic       wdt_ovf_i = 1'b0;
   logic       standby_i = 1'b0;
   logic [5:0] en_i = 6'b0;
   logic       clr_stb_i = 1'b0;
   logic [5:0] clr_mask_i = 6'b0;
   logic [5:0] flags_o;
   logic       int_n_o;
   logic       rst_req_o;

   int checks = 0;
   int errors = 0;
   bit done = 1'b0;

   always #4 clk = ~clk;

   irq_evt_gate #(.SUP_W(3), .BUS_W(3)) u0 (
      .clk(clk), .rst_n(rst_n), .temp_warn_i(temp_warn_i), .gnd_shift_i(gnd_shift_i),
      .batt_ok_i(batt_ok_i), .pwr_good_i(pwr_good_i), .bus_fault_i(bus_fault_i),
      .wdt_ovf_i(wdt_ovf_i), .standby_i(standby_i), .en_i(en_i),
      .clr_stb_i(clr_stb_i), .clr_mask_i(clr_mask_i), .flags_o(flags_o),
      .int_n_o(int_n_o), .rst_req_o(rst_req_o)
   );

   task automatic step();
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic chk(input bit ok, input string req, input int act, input int exp);
      checks++;
      if (!ok) begin
         errors++;
         $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
      end
   endtask

   task automatic chk_flags(input string req, input logic [5:0] exp);
      chk(flags_o == exp, req, int'(flags_o), int'(exp));
      chk(int_n_o == (exp == 6'b0), {req, " int_n R11"}, int'(int_n_o), int'(exp == 6'b0));
   endtask

   task automatic clear_all();
      clr_stb_i = 1'b1; clr_mask_i = 6'h3f;
      step();
      clr_stb_i = 1'b0; clr_mask_i = 6'h00;
   endtask

   task automatic t_reset();
      temp_warn_i = 1'b1; gnd_shift_i = 1'b1; batt_ok_i = 1'b0;
      pwr_good_i = 3'b000; bus_fault_i = 3'b101; en_i = 6'h3f;
      step();
      chk_flags("R1 in reset", 6'h00);
      chk(rst_req_o == 1'b0, "R1 rst_req in reset", int'(rst_req_o), 0);
      rst_n = 1'b1;
      step();
      chk_flags("R1 first edge", 6'h00);
      step();
      chk_flags("R1 settled", 6'h00);
      temp_warn_i = 1'b0; gnd_shift_i = 1'b0; batt_ok_i = 1'b1;
      pwr_good_i = 3'b111; bus_fault_i = 3'b000;
      step();
      clear_all();
      chk_flags("R1 cleared", 6'h00);
   endtask

   task automatic t_temp();
      en_i = 6'h10;
      temp_warn_i = 1'b1; step();
      chk_flags("R2 rise", 6'h10);
      clear_all();
      temp_warn_i = 1'b0; step();
      chk_flags("R2 fall", 6'h10);
      clear_all();
   endtask

   task automatic t_gnd();
      en_i = 6'h08;
      gnd_shift_i = 1'b1; step();
      chk_flags("R3 rise", 6'h08);
      clear_all();
      gnd_shift_i = 1'b0; step();
      chk_flags("R3 fall", 6'h08);
      clear_all();
   endtask

   task automatic t_batt();
      en_i = 6'h04;
      batt_ok_i = 1'b0; step();
      chk_flags("R4 fall", 6'h04);
      clear_all();
      batt_ok_i = 1'b1; step();
      chk_flags("R4 rise ignored", 6'h00);
   endtask

   task automatic t_pwr();
      en_i = 6'h02;
      pwr_good_i = 3'b101; step();
      chk_flags("R5 bit1 drop", 6'h02);
      clear_all();
      pwr_good_i = 3'b111; step();
      chk_flags("R5 rise ignored", 6'h00);
      pwr_good_i = 3'b011; step();
      chk_flags("R5 bit2 drop", 6'h02);
      clear_all();
      pwr_good_i = 3'b111; step();
   endtask

   task automatic t_bus();
      en_i = 6'h01;
      bus_fault_i = 3'b010; step();
      chk_flags("R6 set bit", 6'h01);
      clear_all();
      chk_flags("R6 static", 6'h00);
      bus_fault_i = 3'b100; step();
      chk_flags("R6 swap", 6'h01);
      clear_all();
      bus_fault_i = 3'b000; step();
      chk_flags("R6 to zero", 6'h01);
      clear_all();
   endtask

   task automatic t_wdt();
      standby_i = 1'b1; en_i = 6'h20;
      wdt_ovf_i = 1'b1; step(); wdt_ovf_i = 1'b0;
      chk_flags("R7 irq route", 6'h20);
      chk(rst_req_o == 1'b0, "R7 no reset when irq", int'(rst_req_o), 0);
      clear_all();
      en_i = 6'h00;
      wdt_ovf_i = 1'b1; step(); wdt_ovf_i = 1'b0;
      chk(rst_req_o == 1'b1, "R7 reset route", int'(rst_req_o), 1);
      chk_flags("R7 no flag on reset", 6'h00);
      step();
      chk(rst_req_o == 1'b0, "R7 one-cycle pulse", int'(rst_req_o), 0);
      standby_i = 1'b0; en_i = 6'h20;
      wdt_ovf_i = 1'b1; step(); wdt_ovf_i = 1'b0;
      chk_flags("R7 outside standby flag", 6'h00);
      chk(rst_req_o == 1'b0, "R7 outside standby reset", int'(rst_req_o), 0);
      en_i = 6'h00;
      wdt_ovf_i = 1'b1; step(); wdt_ovf_i = 1'b0;
      chk(rst_req_o == 1'b0, "R7 outside standby no enable", int'(rst_req_o), 0);
   endtask

   task automatic t_disabled();
      en_i = 6'h00; standby_i = 1'b1;
      temp_warn_i = 1'b1; gnd_shift_i = 1'b1; batt_ok_i = 1'b0;
      pwr_good_i = 3'b000; bus_fault_i = 3'b111; en_i = 6'h00;
      step();
      chk_flags("R8 all disabled", 6'h00);
      en_i = 6'h1f; step(); step();
      chk_flags("R8 no retroactive set", 6'h00);
      en_i = 6'h00;
      temp_warn_i = 1'b0; gnd_shift_i = 1'b0; batt_ok_i = 1'b1;
      pwr_good_i = 3'b111; bus_fault_i = 3'b000; standby_i = 1'b0;
      step();
      chk_flags("R8 restore disabled", 6'h00);
   endtask

   task automatic t_clear();
      en_i = 6'h1f;
      temp_warn_i = 1'b1; gnd_shift_i = 1'b1; batt_ok_i = 1'b0;
      pwr_good_i = 3'b110; bus_fault_i = 3'b001;
      step();
      en_i = 6'h00;
      chk_flags("R9 all set", 6'h1f);
      step(); step();
      chk_flags("R9 sticky", 6'h1f);
      clr_mask_i = 6'h0a; step();
      chk_flags("R9 mask without strobe", 6'h1f);
      clr_stb_i = 1'b1; step(); clr_stb_i = 1'b0; clr_mask_i = 6'h00;
      chk_flags("R9 partial clear", 6'h15);
      clear_all();
      chk_flags("R9 full clear", 6'h00);
      temp_warn_i = 1'b0; gnd_shift_i = 1'b0; batt_ok_i = 1'b1;
      pwr_good_i = 3'b111; bus_fault_i = 3'b000;
      step();
   endtask

   task automatic t_collide();
      en_i = 6'h04;
      batt_ok_i = 1'b0; step();
      batt_ok_i = 1'b1; step();
      chk_flags("R10 preset", 6'h04);
      batt_ok_i = 1'b0; clr_stb_i = 1'b1; clr_mask_i = 6'h3f;
      step();
      clr_stb_i = 1'b0; clr_mask_i = 6'h00;
      chk_flags("R10 event beats clear", 6'h04);
      clear_all();
      batt_ok_i = 1'b1; step();
   endtask

   initial begin
      @(negedge clk);
      t_reset();
      t_temp();
      t_gnd();
      t_batt();
      t_pwr();
      t_bus();
      t_wdt();
      t_disabled();
      t_clear();
      t_collide();
      done = 1'b1;
   end

   initial begin
      fork
         wait (done);
         begin
            repeat (20000) @(posedge clk);
            checks++; errors++;
            $display("FAIL watchdog: actual timeout expected completion");
         end
      join_any
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
   end
endmodule